// File: doc/BRIEF.md
# Write-Update Snooping Cache Line Controller

This block is the line-state and control part of one processor's cache in a shared-bus multiprocessor. A small direct-mapped array holds a tag, a one-word copy of the data, a state and a dirty flag for each line. A line is absent, shared or exclusive. Reads that hit and writes to exclusive lines finish inside the cache. A write to a shared line is broadcast on the bus as an update, so every other holder refreshes its copy. A line is installed exclusive only when no other cache reports a copy.

The controller also watches the bus traffic of the other caches. It answers with a "copy held" signal, provides dirty data when a peer reads a line it holds, and adjusts its own lines to match. The processor sees a stall output and a one-cycle completion pulse. Bus arbitration, main memory and the fabric that combines the copy-held signals of all caches are outside the block.

Top module: `snoop_update_cache`

## Requirements
- R1: After reset every line is absent. `cpu_stall`, `bus_req` and `cpu_done` are low, and no snoop sees a copy.
- R2: A read miss issues a bus transaction of kind 0 (read) at the requested address. The cycle after `bus_ack`, `cpu_done` pulses with `bus_rdata` on `cpu_rdata`. The line is installed shared if `bus_shared` was high at the ack, and exclusive otherwise.
- R3: A read hit needs no bus transaction. `cpu_done` pulses the cycle after acceptance, with the line's data on `cpu_rdata`.
- R4: A write to an exclusive line updates the local copy and marks it dirty, without a bus transaction. `cpu_done` pulses the next cycle.
- R5: A write to a shared line issues kind 1 (update) carrying the address and the new data. After the ack the line stays shared if `bus_shared` was high, and becomes exclusive otherwise.
- R6: A write miss issues kind 1 (update) with the new data. The line is installed with that data, shared or exclusive according to `bus_shared` at the ack.
- R7: A miss whose victim line is exclusive and dirty first issues kind 2 (write-back), carrying the victim's address (tag above the index) and its data. The fill or update transaction follows.
- R8: A snooped read (kind 0) of a held line raises `snp_has_copy` in the same cycle and leaves the line shared. If the line was dirty, `snp_supply` is also raised, with the line data on `snp_data`.
- R9: A snooped update (kind 1) of a held line raises `snp_has_copy`, overwrites the local data and leaves the line shared.
- R10: While a bus transaction is outstanding, `cpu_stall` is high. `bus_req`, `bus_kind` and `bus_addr` stay stable until `bus_ack`.
- R11: When a valid snoop and a processor request use the same index in the same cycle, the snoop is served and `cpu_stall` is high for that cycle.
- R12: A snooped write-back (kind 2) and a snoop to an address that is not held both leave `snp_has_copy` low and change no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address; low IW bits are the index |
| cpu_wdata | input | DW | Write data |
| cpu_stall | output | 1 | Request not accepted this cycle |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read result, valid with `cpu_done` |
| bus_req | output | 1 | Bus transaction requested |
| bus_kind | output | 2 | 0 read, 1 update, 2 write-back |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Update or write-back data |
| bus_ack | input | 1 | Transaction performed this cycle |
| bus_rdata | input | DW | Fill data, valid with `bus_ack` |
| bus_shared | input | 1 | Another cache holds the line, valid with `bus_ack` |
| snp_valid | input | 1 | A peer transaction is on the bus |
| snp_kind | input | 2 | Kind of the peer transaction |
| snp_addr | input | AW | Address of the peer transaction |
| snp_wdata | input | DW | Data of a peer update |
| snp_has_copy | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache supplies dirty data |
| snp_data | output | DW | Supplied line data |

## Verification
Hits and exclusive writes complete one cycle after acceptance. A bus request appears in the cycle after acceptance, or in the cycle after a write-back's ack. Completion comes one cycle after the final ack. Snoop responses are combinational in the snoop cycle, and their effect on a line shows in the next request. The bench drives inputs on the falling edge and checks combinational outputs shortly after. It checks registered outputs at the falling edge that follows the expected rising edge. It learns whether a line is shared or exclusive from whether the next write to it goes to the bus.

// File: rtl/snc_pkg.sv
// Shared types of the snooping write-update cache controller.
// Assumes: encodings below are fixed, the bus fabric decodes the kind field.
package snc_pkg;
    typedef enum logic [1:0] {
        LN_ABSENT = 2'd0,
        LN_SHARED = 2'd1,
        LN_EXCL   = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BK_READ   = 2'd0,
        BK_UPDATE = 2'd1,
        BK_WBACK  = 2'd2
    } bus_kind_e;

    typedef enum logic [1:0] {
        F_IDLE  = 2'd0,
        F_WBACK = 2'd1,
        F_XFER  = 2'd2
    } fsm_e;
endpackage

// File: rtl/snc_line_array.sv
// Direct-mapped tag/state/dirty/data store with two lookup ports.
// Assumes: the snoop update wins over the processor update on the same index.
module snc_line_array
    import snc_pkg::*;
#(
    parameter int IW = 3,
    parameter int TW = 5,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] p_idx,
    output logic [TW-1:0] p_tag,
    output line_st_e      p_st,
    output logic          p_dirty,
    output logic [DW-1:0] p_data,
    input  logic          p_we,
    input  logic [TW-1:0] p_tag_nxt,
    input  line_st_e      p_st_nxt,
    input  logic          p_dirty_nxt,
    input  logic [DW-1:0] p_data_nxt,
    input  logic [IW-1:0] s_idx,
    output logic [TW-1:0] s_tag,
    output line_st_e      s_st,
    output logic          s_dirty,
    output logic [DW-1:0] s_data,
    input  logic          s_we,
    input  logic          s_data_we,
    input  logic [DW-1:0] s_data_nxt
);
    localparam int LINES = 1 << IW;

    logic [TW-1:0] tag_q   [LINES];
    line_st_e      st_q    [LINES];
    logic          dirty_q [LINES];
    logic [DW-1:0] data_q  [LINES];

    // Combinational lookups for both ports.
    always_comb begin
        p_tag   = tag_q[p_idx];
        p_st    = st_q[p_idx];
        p_dirty = dirty_q[p_idx];
        p_data  = data_q[p_idx];
        s_tag   = tag_q[s_idx];
        s_st    = st_q[s_idx];
        s_dirty = dirty_q[s_idx];
        s_data  = data_q[s_idx];
    end

    // State and dirty flags: reset to absent, snoop write applied last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]    <= LN_ABSENT;
                dirty_q[i] <= 1'b0;
            end
        end else begin
            if (p_we) begin
                st_q[p_idx]    <= p_st_nxt;
                dirty_q[p_idx] <= p_dirty_nxt;
            end
            if (s_we) begin
                st_q[s_idx]    <= LN_SHARED;
                dirty_q[s_idx] <= 1'b0;
            end
        end
    end

    // Tag and data words: no reset needed, guarded by the state.
    always_ff @(posedge clk) begin
        if (p_we) begin
            tag_q[p_idx]  <= p_tag_nxt;
            data_q[p_idx] <= p_data_nxt;
        end
        if (s_data_we) begin
            data_q[s_idx] <= s_data_nxt;
        end
    end
endmodule

// File: rtl/snc_snoop.sv
// Snoop response logic: decides copy-held, dirty supply and the line change.
// Assumes: the write-back kind never touches a peer's copy.
module snc_snoop
    import snc_pkg::*;
#(
    parameter int TW = 5,
    parameter int DW = 16
) (
    input  logic          snp_valid,
    input  logic [1:0]    snp_kind,
    input  logic [TW-1:0] snp_tag,
    input  logic [TW-1:0] ln_tag,
    input  line_st_e      ln_st,
    input  logic          ln_dirty,
    input  logic [DW-1:0] ln_data,
    output logic          has_copy,
    output logic          supply,
    output logic [DW-1:0] data_out,
    output logic          ln_we,
    output logic          ln_data_we
);
    logic hit;

    // Match a peer transaction against the indexed line.
    always_comb begin
        hit        = snp_valid && (snp_kind != BK_WBACK) &&
                     (ln_st != LN_ABSENT) && (ln_tag == snp_tag);
        has_copy   = hit;
        supply     = hit && (snp_kind == BK_READ) && ln_dirty;
        data_out   = ln_data;
        ln_we      = hit;
        ln_data_we = hit && (snp_kind == BK_UPDATE);
    end
endmodule

// File: rtl/snoop_update_cache.sv
// Per-processor cache controller with write-update snooping.
// Assumes: one outstanding processor request, no snoop during this cache's ack.
module snoop_update_cache
    import snc_pkg::*;
#(
    parameter int AW = 8,
    parameter int IW = 3,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_valid,
    input  logic          cpu_write,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_stall,
    output logic          cpu_done,
    output logic [DW-1:0] cpu_rdata,
    output logic          bus_req,
    output logic [1:0]    bus_kind,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_shared,
    input  logic          snp_valid,
    input  logic [1:0]    snp_kind,
    input  logic [AW-1:0] snp_addr,
    input  logic [DW-1:0] snp_wdata,
    output logic          snp_has_copy,
    output logic          snp_supply,
    output logic [DW-1:0] snp_data
);
    localparam int TW = AW - IW;

    fsm_e          fsm_q;
    logic          pend_wr_q;
    logic [AW-1:0] pend_addr_q;
    logic [DW-1:0] pend_wdata_q;
    bus_kind_e     pend_kind_q;
    logic          done_q;
    logic [DW-1:0] rdata_q;

    logic [IW-1:0] lk_idx;
    logic [TW-1:0] lk_tag, s_tag;
    line_st_e      lk_st, s_st;
    logic          lk_dirty, s_dirty;
    logic [DW-1:0] lk_data, s_data;
    logic          p_we;
    logic [TW-1:0] p_tag_nxt;
    line_st_e      p_st_nxt;
    logic          p_dirty_nxt;
    logic [DW-1:0] p_data_nxt;
    logic          s_we, s_data_we;
    logic          conflict, accept, hit;

    // Lookup index follows the pending request while the bus is busy.
    always_comb begin
        lk_idx   = (fsm_q == F_IDLE) ? cpu_addr[IW-1:0] : pend_addr_q[IW-1:0];
        hit      = (lk_st != LN_ABSENT) && (lk_tag == cpu_addr[AW-1:IW]);
        conflict = snp_valid && (snp_addr[IW-1:0] == cpu_addr[IW-1:0]);
        cpu_stall = (fsm_q != F_IDLE) || conflict;
        accept   = cpu_valid && !cpu_stall;
    end

    // Bus master outputs, taken from the FSM and the pending request.
    always_comb begin
        bus_req   = (fsm_q != F_IDLE);
        bus_kind  = (fsm_q == F_WBACK) ? BK_WBACK : pend_kind_q;
        bus_addr  = (fsm_q == F_WBACK) ? {lk_tag, lk_idx} : pend_addr_q;
        bus_wdata = (fsm_q == F_WBACK) ? lk_data : pend_wdata_q;
    end

    // Processor-side line update: local write, fill/update install, eviction.
    always_comb begin
        p_we        = 1'b0;
        p_tag_nxt   = pend_addr_q[AW-1:IW];
        p_st_nxt    = bus_shared ? LN_SHARED : LN_EXCL;
        p_dirty_nxt = 1'b0;
        p_data_nxt  = pend_wr_q ? pend_wdata_q : bus_rdata;
        unique case (fsm_q)
            F_IDLE: begin
                if (accept && cpu_write && hit && lk_st == LN_EXCL) begin
                    p_we        = 1'b1;
                    p_tag_nxt   = lk_tag;
                    p_st_nxt    = LN_EXCL;
                    p_dirty_nxt = 1'b1;
                    p_data_nxt  = cpu_wdata;
                end
            end
            F_WBACK: begin
                if (bus_ack) begin
                    p_we       = 1'b1;
                    p_tag_nxt  = lk_tag;
                    p_st_nxt   = LN_ABSENT;
                    p_data_nxt = lk_data;
                end
            end
            F_XFER: p_we = bus_ack;
            default: p_we = 1'b0;
        endcase
    end

    // Request sequencing and the registered processor response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q        <= F_IDLE;
            pend_wr_q    <= 1'b0;
            pend_addr_q  <= '0;
            pend_wdata_q <= '0;
            pend_kind_q  <= BK_READ;
            done_q       <= 1'b0;
            rdata_q      <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (fsm_q)
                F_IDLE: begin
                    if (accept) begin
                        pend_wr_q    <= cpu_write;
                        pend_addr_q  <= cpu_addr;
                        pend_wdata_q <= cpu_wdata;
                        pend_kind_q  <= cpu_write ? BK_UPDATE : BK_READ;
                        if (hit && !(cpu_write && lk_st == LN_SHARED)) begin
                            done_q  <= 1'b1;
                            rdata_q <= cpu_write ? cpu_wdata : lk_data;
                        end else if (!hit && lk_st == LN_EXCL && lk_dirty) begin
                            fsm_q <= F_WBACK;
                        end else begin
                            fsm_q <= F_XFER;
                        end
                    end
                end
                F_WBACK: if (bus_ack) fsm_q <= F_XFER;
                F_XFER: begin
                    if (bus_ack) begin
                        fsm_q   <= F_IDLE;
                        done_q  <= 1'b1;
                        rdata_q <= pend_wr_q ? pend_wdata_q : bus_rdata;
                    end
                end
                default: fsm_q <= F_IDLE;
            endcase
        end
    end

    assign cpu_done  = done_q;
    assign cpu_rdata = rdata_q;

    snc_line_array #(.IW(IW), .TW(TW), .DW(DW)) i_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .p_idx       (lk_idx),
        .p_tag       (lk_tag),
        .p_st        (lk_st),
        .p_dirty     (lk_dirty),
        .p_data      (lk_data),
        .p_we        (p_we),
        .p_tag_nxt   (p_tag_nxt),
        .p_st_nxt    (p_st_nxt),
        .p_dirty_nxt (p_dirty_nxt),
        .p_data_nxt  (p_data_nxt),
        .s_idx       (snp_addr[IW-1:0]),
        .s_tag       (s_tag),
        .s_st        (s_st),
        .s_dirty     (s_dirty),
        .s_data      (s_data),
        .s_we        (s_we),
        .s_data_we   (s_data_we),
        .s_data_nxt  (snp_wdata)
    );

    snc_snoop #(.TW(TW), .DW(DW)) i_snoop (
        .snp_valid  (snp_valid),
        .snp_kind   (snp_kind),
        .snp_tag    (snp_addr[AW-1:IW]),
        .ln_tag     (s_tag),
        .ln_st      (s_st),
        .ln_dirty   (s_dirty),
        .ln_data    (s_data),
        .has_copy   (snp_has_copy),
        .supply     (snp_supply),
        .data_out   (snp_data),
        .ln_we      (s_we),
        .ln_data_we (s_data_we)
    );
endmodule

// File: rtl/snc_checker.sv
// Protocol checks for snoop_update_cache, bound to every instance.
// Assumes: synchronous active-low reset, kinds 0 read, 1 update, 2 write-back.
module snc_checker #(
    parameter int AW = 8,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_valid,
    input logic [AW-1:0] cpu_addr,
    input logic          cpu_stall,
    input logic          cpu_done,
    input logic          bus_req,
    input logic [1:0]    bus_kind,
    input logic [AW-1:0] bus_addr,
    input logic          bus_ack,
    input logic          snp_valid,
    input logic [1:0]    snp_kind,
    input logic [AW-1:0] snp_addr,
    input logic          snp_has_copy,
    input logic          snp_supply
);
    p_busy_stalls_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> cpu_stall);

    p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_kind)));

    p_snoop_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && cpu_valid && snp_addr[IW-1:0] == cpu_addr[IW-1:0]) |-> cpu_stall);

    p_supply_needs_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> (snp_has_copy && snp_kind == 2'd0));

    p_wback_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_kind == 2'd2) |-> !snp_has_copy);

    p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !bus_req);

    p_wback_then_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && bus_kind == 2'd2) |=> (bus_req && bus_kind != 2'd2));
endmodule

bind snoop_update_cache snc_checker #(.AW(AW), .IW(IW)) i_snc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_valid    (cpu_valid),
    .cpu_addr     (cpu_addr),
    .cpu_stall    (cpu_stall),
    .cpu_done     (cpu_done),
    .bus_req      (bus_req),
    .bus_kind     (bus_kind),
    .bus_addr     (bus_addr),
    .bus_ack      (bus_ack),
    .snp_valid    (snp_valid),
    .snp_kind     (snp_kind),
    .snp_addr     (snp_addr),
    .snp_has_copy (snp_has_copy),
    .snp_supply   (snp_supply)
);

// File: tb/test_snoop_update_cache.sv
`timescale 1ns/1ps
// Bench for snoop_update_cache: vector table of processor operations,
// then directed tests for reset, eviction and snooping.
module test_snoop_update_cache;
    localparam int AW = 8;
    localparam int IW = 3;
    localparam int DW = 16;

    typedef struct packed {
        logic          wr;
        logic [7:0]    addr;
        logic [15:0]   wdata;
        logic [1:0]    bx;     // 0 none, 1 read transaction, 2 update transaction
        logic          shr;
        logic [15:0]   rd;
        logic [15:0]   ex;
        logic [3:0]    rq;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h10, 16'h0000, 2'd1, 1'b0, 16'h1111, 16'h1111, 4'd2}, // R2 miss, exclusive
        '{1'b0, 8'h10, 16'h0000, 2'd0, 1'b0, 16'h0000, 16'h1111, 4'd3}, // R3 hit
        '{1'b1, 8'h10, 16'hAAAA, 2'd0, 1'b0, 16'h0000, 16'hAAAA, 4'd4}, // R4 local write
        '{1'b0, 8'h10, 16'h0000, 2'd0, 1'b0, 16'h0000, 16'hAAAA, 4'd4}, // R4 read back
        '{1'b0, 8'h21, 16'h0000, 2'd1, 1'b1, 16'h2222, 16'h2222, 4'd2}, // R2 miss, shared
        '{1'b1, 8'h21, 16'hBBBB, 2'd2, 1'b1, 16'h0000, 16'hBBBB, 4'd5}, // R5 stays shared
        '{1'b1, 8'h21, 16'hCCCC, 2'd2, 1'b0, 16'h0000, 16'hCCCC, 4'd5}, // R5 becomes exclusive
        '{1'b1, 8'h21, 16'hDDDD, 2'd0, 1'b0, 16'h0000, 16'hDDDD, 4'd5}, // R5 now local
        '{1'b1, 8'h32, 16'h3333, 2'd2, 1'b1, 16'h0000, 16'h3333, 4'd6}, // R6 write miss
        '{1'b0, 8'h32, 16'h0000, 2'd0, 1'b0, 16'h0000, 16'h3333, 4'd6}, // R6 data installed
        '{1'b1, 8'h32, 16'h4444, 2'd2, 1'b0, 16'h0000, 16'h4444, 4'd6}  // R6 shared install
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_valid = 1'b0, cpu_write = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_stall, cpu_done;
    logic [DW-1:0] cpu_rdata;
    logic          bus_req;
    logic [1:0]    bus_kind;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_ack = 1'b0, bus_shared = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_kind = '0;
    logic [AW-1:0] snp_addr = '0;
    logic [DW-1:0] snp_wdata = '0;
    logic          snp_has_copy, snp_supply;
    logic [DW-1:0] snp_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    snoop_update_cache #(.AW(AW), .IW(IW), .DW(DW)) i_snoop_update_cache (.*);

    task automatic chk(input logic ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic cpu_op(input logic wr, input logic [7:0] a, input logic [15:0] wd,
                          input logic [1:0] bx, input logic sh, input logic [15:0] rd,
                          input logic [15:0] ex, input string rq);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_wdata = wd;
        #1 chk(cpu_stall == 1'b0, rq, "accepted", 32'(cpu_stall), 0);
        @(posedge clk);
        @(negedge clk);
        cpu_valid = 1'b0;
        if (bx == 2'd0) begin
            chk(bus_req == 1'b0, rq, "no bus", 32'(bus_req), 0);
            chk(cpu_done == 1'b1, rq, "done", 32'(cpu_done), 1);
            if (!wr) chk(cpu_rdata == ex, rq, "rdata", 32'(cpu_rdata), 32'(ex));
        end else begin
            chk(bus_req == 1'b1 && bus_kind == bx - 2'd1, rq, "bus kind",
                32'(bus_kind), 32'(bx - 2'd1));
            chk(bus_addr == a, rq, "bus addr", 32'(bus_addr), 32'(a));
            if (wr) chk(bus_wdata == wd, rq, "bus data", 32'(bus_wdata), 32'(wd));
            chk(cpu_stall == 1'b1, "R10", "stall busy", 32'(cpu_stall), 1);
            bus_ack = 1'b1; bus_shared = sh; bus_rdata = rd;
            @(posedge clk);
            @(negedge clk);
            bus_ack = 1'b0; bus_shared = 1'b0;
            chk(cpu_done == 1'b1, rq, "done", 32'(cpu_done), 1);
            if (!wr) chk(cpu_rdata == ex, rq, "rdata", 32'(cpu_rdata), 32'(ex));
        end
    endtask

    task automatic snoop(input logic [1:0] k, input logic [7:0] a, input logic [15:0] wd,
                         input logic ec, input logic es, input logic [15:0] ed,
                         input string rq);
        @(negedge clk);
        snp_valid = 1'b1; snp_kind = k; snp_addr = a; snp_wdata = wd;
        #1;
        chk(snp_has_copy == ec, rq, "has copy", 32'(snp_has_copy), 32'(ec));
        chk(snp_supply == es, rq, "supply", 32'(snp_supply), 32'(es));
        if (es) chk(snp_data == ed, rq, "supplied data", 32'(snp_data), 32'(ed));
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        chk(cpu_stall == 1'b0, "R1", "stall", 32'(cpu_stall), 0);
        chk(bus_req == 1'b0, "R1", "bus_req", 32'(bus_req), 0);
        chk(cpu_done == 1'b0, "R1", "done", 32'(cpu_done), 0);
        snoop(2'd0, 8'h10, 16'h0, 1'b0, 1'b0, 16'h0, "R1");

        for (int i = 0; i < NV; i++) begin
            cpu_op(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].bx, VECS[i].shr,
                   VECS[i].rd, VECS[i].ex, $sformatf("R%0d", VECS[i].rq));
        end

        // R7 dirty exclusive victim at index 0 (0x10 holds AAAA), fill 0x18
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = 8'h18;
        @(posedge clk);
        @(negedge clk);
        cpu_valid = 1'b0;
        chk(bus_req && bus_kind == 2'd2, "R7", "write-back kind", 32'(bus_kind), 2);
        chk(bus_addr == 8'h10, "R7", "victim addr", 32'(bus_addr), 32'h10);
        chk(bus_wdata == 16'hAAAA, "R7", "victim data", 32'(bus_wdata), 32'hAAAA);
        @(negedge clk);
        chk(bus_req && bus_addr == 8'h10 && bus_kind == 2'd2, "R10", "held",
            32'(bus_addr), 32'h10);
        bus_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_ack = 1'b0;
        chk(bus_req && bus_kind == 2'd0 && bus_addr == 8'h18, "R7", "fill follows",
            32'(bus_addr), 32'h18);
        bus_ack = 1'b1; bus_rdata = 16'h5555; bus_shared = 1'b0;
        @(posedge clk);
        @(negedge clk);
        bus_ack = 1'b0;
        chk(cpu_done && cpu_rdata == 16'h5555, "R7", "fill data", 32'(cpu_rdata), 32'h5555);

        // R8 snooped read: exclusive clean -> shared, then dirty supply
        snoop(2'd0, 8'h18, 16'h0, 1'b1, 1'b0, 16'h0, "R8");
        cpu_op(1'b1, 8'h18, 16'h6666, 2'd2, 1'b0, 16'h0, 16'h6666, "R8");
        cpu_op(1'b1, 8'h18, 16'h7777, 2'd0, 1'b0, 16'h0, 16'h7777, "R8");
        snoop(2'd0, 8'h18, 16'h0, 1'b1, 1'b1, 16'h7777, "R8");
        cpu_op(1'b1, 8'h18, 16'h8888, 2'd2, 1'b1, 16'h0, 16'h8888, "R8");

        // R9 snooped update overwrites and forces shared
        snoop(2'd1, 8'h21, 16'h9999, 1'b1, 1'b0, 16'h0, "R9");
        cpu_op(1'b0, 8'h21, 16'h0, 2'd0, 1'b0, 16'h0, 16'h9999, "R9");
        cpu_op(1'b1, 8'h21, 16'hABCD, 2'd2, 1'b1, 16'h0, 16'hABCD, "R9");

        // R12 write-back snoop and unheld address ignored
        snoop(2'd2, 8'h32, 16'hFFFF, 1'b0, 1'b0, 16'h0, "R12");
        snoop(2'd1, 8'h3A, 16'hEEEE, 1'b0, 1'b0, 16'h0, "R12");
        cpu_op(1'b0, 8'h32, 16'h0, 2'd0, 1'b0, 16'h0, 16'h4444, "R12");

        // R11 same-index snoop takes priority over processor request
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = 8'h21;
        snp_valid = 1'b1; snp_kind = 2'd0; snp_addr = 8'h29;
        #1 chk(cpu_stall == 1'b1, "R11", "stall on conflict", 32'(cpu_stall), 1);
        @(posedge clk);
        @(negedge clk);
        cpu_valid = 1'b0; snp_valid = 1'b0;
        chk(cpu_done == 1'b0, "R11", "not accepted", 32'(cpu_done), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule